// File: doc/BRIEF.md
# SDRAM Mode Word Burst Timing Unit

This unit sits on the controller side of an SDRAM interface. It holds the active mode word and uses it to schedule the clock-accurate timing of read and write bursts. A load command writes a new mode word. The unit checks the word before taking it. A word with a reserved field, or with a CAS latency that the configured clock frequency does not allow, is rejected and flagged, and the previous settings stay in force.

After a READ, the unit raises a bus-drive indication one cycle before the first data beat. It then holds a data-valid strobe for exactly the programmed number of beats. After a WRITE, it produces one write strobe per beat. A single-write bit can cut every write to one beat while reads keep bursting. Commands that arrive during a burst are dropped, and a one-cycle busy error is reported.

The scheduler is a five-state machine:
- IDLE moves to RD_WAIT on a READ and to WR_BURST on a WRITE.
- RD_WAIT counts the latency down and moves to RD_LEAD.
- RD_LEAD always moves to RD_BURST on the next edge.
- RD_BURST and WR_BURST count beats down and return to IDLE when the last beat is done.

Top module: `sdram_burst_timer`

## Requirements
- R1: After reset the unit is idle. It has CAS latency 3, burst length 1 and the single-write bit clear. `busy`, `bus_drive`, `data_valid`, `wr_strobe` and all error outputs are low.
- R2: The `cmd` encoding is 00 NOP, 01 READ, 10 WRITE, 11 LOAD. The `mode_word` fields are decoded as follows:
  - bits [2:0] give the burst length: 000 means 1, 001 means 2, 010 means 4, 011 means 8, 111 means `PAGE_LEN`.
  - bits [6:4] give the CAS latency: 010 means 2, 011 means 3.
  - bits [8:7] must be 00.
  - bit 9 is the single-write bit.
  - bit 3 is not decoded.
  
  A valid LOAD while idle takes effect for commands from the next cycle on.
- R3: A LOAD is rejected if it has bits [8:7] not equal to 00, a burst code outside the list in R2, or a latency code other than 010 or 011. The rejection raises `err_reserved` for the one cycle after the LOAD, and the previous settings are kept.
- R4: A latency code is rejected when `CLK_MHZ` exceeds the limit for that latency: `CL2_MAX_MHZ` for latency 2, `CL3_MAX_MHZ` for latency 3. The rejection raises `err_speed` for one cycle and keeps the previous settings.
- R5: For a READ registered at edge n with latency m, `bus_drive` is high from the cycle after edge n+m-1. During that first cycle `data_valid` is still low.
- R6: `data_valid` is high for exactly burst-length consecutive cycles, starting in the cycle after edge n+m.
- R7: `bus_drive` stays high through the last data beat and is low in the cycle that follows it.
- R8: With the single-write bit clear, a WRITE gives `wr_strobe` high for burst-length consecutive cycles, starting in the cycle after the WRITE edge. `bus_drive` stays low throughout.
- R9: With the single-write bit set, every WRITE gives exactly one `wr_strobe` cycle, while READ bursts still use the programmed length.
- R10: `busy` is high from the cycle after an accepted READ or WRITE until the last strobe cycle ends. A READ, WRITE or LOAD presented while `busy` is high is ignored and raises `err_busy` for the following cycle.
- R11: NOP commands leave all outputs and the stored settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: 00 NOP, 01 READ, 10 WRITE, 11 LOAD |
| mode_word | input | 10 | Mode word sampled with LOAD |
| bus_drive | output | 1 | Data bus driven for a read |
| data_valid | output | 1 | Read data beat valid |
| wr_strobe | output | 1 | Write beat strobe |
| busy | output | 1 | Burst in progress |
| err_busy | output | 1 | Command dropped while busy (one-cycle pulse) |
| err_reserved | output | 1 | LOAD rejected for a reserved field (one-cycle pulse) |
| err_speed | output | 1 | LOAD rejected for latency versus clock frequency (one-cycle pulse) |

## Verification
The bench targets the following cases:
- **Latency counting.** An off-by-one in the latency countdown shifts the first beat. This shows up as a first-drive or first-valid cycle that is one edge early or late, for both latency 2 and latency 3.
- **Burst limits.** Full-page and length-1 bursts test the beat counter at its extremes. A wrong counter gives too few or too many valid cycles, or leaves `bus_drive` hanging after the last beat.
- **Rejected loads.** Words that are reserved, or too fast for the clock, must leave the old timing in place. A separate instance runs at a faster clock so that latency 2 is refused.
- **Commands while busy.** Commands injected during a burst must neither restart the burst nor change the settings. A design that accepts them would show a longer burst or different later timing.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_LOAD  = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_LEAD,
        ST_RD_BURST,
        ST_WR_BURST
    } state_e;

    typedef struct packed {
        logic       cl3;
        logic [2:0] bl_code;
        logic       wr_single;
    } cfg_t;

    localparam int MODE_W = 10;

endpackage

// File: rtl/sbt_mode_decode.sv
module sbt_mode_decode
    import sbt_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int CL2_MAX_MHZ = 100,
    parameter int CL3_MAX_MHZ = 125
) (
    input  logic [MODE_W-1:0] word,
    output cfg_t              cfg_new,
    output logic              reserved_bad,
    output logic              speed_bad
);

    localparam logic CL2_ALLOWED = (CLK_MHZ <= CL2_MAX_MHZ);
    localparam logic CL3_ALLOWED = (CLK_MHZ <= CL3_MAX_MHZ);

    logic op_ok;
    logic bl_ok;
    logic is_cl2;
    logic is_cl3;

    always_comb begin
        op_ok  = (word[8:7] == 2'b00);
        bl_ok  = (word[2] == 1'b0) || (word[2:0] == 3'b111);
        is_cl2 = (word[6:4] == 3'b010);
        is_cl3 = (word[6:4] == 3'b011);

        reserved_bad = !op_ok || !bl_ok || !(is_cl2 || is_cl3);
        speed_bad    = !reserved_bad &&
                       ((is_cl2 && !CL2_ALLOWED) || (is_cl3 && !CL3_ALLOWED));

        cfg_new.cl3       = is_cl3;
        cfg_new.bl_code   = word[2:0];
        cfg_new.wr_single = word[9];
    end

endmodule

// File: rtl/sbt_mode_reg.sv
module sbt_mode_reg
    import sbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic reserved_bad,
    input  logic speed_bad,
    input  cfg_t cfg_new,
    output cfg_t cfg,
    output logic err_reserved,
    output logic err_speed
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.cl3       <= 1'b1;
            cfg.bl_code   <= 3'b000;
            cfg.wr_single <= 1'b0;
            err_reserved  <= 1'b0;
            err_speed     <= 1'b0;
        end else begin
            err_reserved <= load_en && reserved_bad;
            err_speed    <= load_en && speed_bad;
            if (load_en && !reserved_bad && !speed_bad) begin
                cfg <= cfg_new;
            end
        end
    end

endmodule

// File: rtl/sbt_burst_fsm.sv
module sbt_burst_fsm
    import sbt_pkg::*;
#(
    parameter int PAGE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  cfg_t cfg,
    output logic idle,
    output logic busy,
    output logic bus_drive,
    output logic data_valid,
    output logic wr_strobe,
    output logic err_busy
);

    localparam int CNT_W = $clog2(PAGE_LEN);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             err_busy_q, err_busy_d;
    logic [CNT_W-1:0] beats_m1;

    // Burst length minus one, from the length code.
    always_comb begin
        unique case (cfg.bl_code)
            3'b000:  beats_m1 = CNT_W'(0);
            3'b001:  beats_m1 = CNT_W'(1);
            3'b010:  beats_m1 = CNT_W'(3);
            3'b011:  beats_m1 = CNT_W'(7);
            default: beats_m1 = CNT_W'(PAGE_LEN - 1);
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        err_busy_d = (state_q != ST_IDLE) && (cmd != CMD_NOP);
        unique case (state_q)
            ST_IDLE: begin
                if (cmd == CMD_READ) begin
                    state_d = ST_RD_WAIT;
                    cnt_d   = cfg.cl3 ? CNT_W'(1) : CNT_W'(0);
                end else if (cmd == CMD_WRITE) begin
                    state_d = ST_WR_BURST;
                    cnt_d   = cfg.wr_single ? CNT_W'(0) : beats_m1;
                end
            end
            ST_RD_WAIT: begin
                if (cnt_q == '0) state_d = ST_RD_LEAD;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_RD_LEAD: begin
                state_d = ST_RD_BURST;
                cnt_d   = beats_m1;
            end
            ST_RD_BURST, ST_WR_BURST: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            err_busy_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            err_busy_q <= err_busy_d;
        end
    end

    // Outputs, decoded from the registered state
    always_comb begin
        idle       = (state_q == ST_IDLE);
        busy       = !idle;
        bus_drive  = (state_q == ST_RD_LEAD) || (state_q == ST_RD_BURST);
        data_valid = (state_q == ST_RD_BURST);
        wr_strobe  = (state_q == ST_WR_BURST);
        err_busy   = err_busy_q;
    end

endmodule

// File: rtl/sdram_burst_timer.sv
module sdram_burst_timer
    import sbt_pkg::*;
#(
    parameter int PAGE_LEN    = 16,
    parameter int CLK_MHZ     = 100,
    parameter int CL2_MAX_MHZ = 100,
    parameter int CL3_MAX_MHZ = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [MODE_W-1:0] mode_word,
    output logic              bus_drive,
    output logic              data_valid,
    output logic              wr_strobe,
    output logic              busy,
    output logic              err_busy,
    output logic              err_reserved,
    output logic              err_speed
);

    cmd_e cmd_t;
    cfg_t cfg_new;
    cfg_t cfg;
    logic reserved_bad;
    logic speed_bad;
    logic idle;
    logic load_en;

    assign cmd_t   = cmd_e'(cmd);
    assign load_en = (cmd_t == CMD_LOAD) && idle;

    sbt_mode_decode #(
        .CLK_MHZ    (CLK_MHZ),
        .CL2_MAX_MHZ(CL2_MAX_MHZ),
        .CL3_MAX_MHZ(CL3_MAX_MHZ)
    ) u_decode (
        .word        (mode_word),
        .cfg_new     (cfg_new),
        .reserved_bad(reserved_bad),
        .speed_bad   (speed_bad)
    );

    sbt_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .reserved_bad(reserved_bad),
        .speed_bad   (speed_bad),
        .cfg_new     (cfg_new),
        .cfg         (cfg),
        .err_reserved(err_reserved),
        .err_speed   (err_speed)
    );

    sbt_burst_fsm #(
        .PAGE_LEN(PAGE_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd_t),
        .cfg       (cfg),
        .idle      (idle),
        .busy      (busy),
        .bus_drive (bus_drive),
        .data_valid(data_valid),
        .wr_strobe (wr_strobe),
        .err_busy  (err_busy)
    );

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd,
    input logic       busy,
    input logic       bus_drive,
    input logic       data_valid,
    input logic       wr_strobe,
    input logic       err_busy
);

    // R1
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_drive && !data_valid && !wr_strobe));

    // R6
    valid_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> bus_drive);

    // R5
    lead_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_drive) |-> !data_valid);

    // R5
    lead_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_drive) |=> data_valid);

    // R7
    drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid) |-> !bus_drive);

    // R8
    no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && bus_drive));

    // R10
    busy_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |-> $past(busy));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (cmd == 2'b01 || cmd == 2'b10)) |=> busy);

endmodule

bind sdram_burst_timer sbt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .busy      (busy),
    .bus_drive (bus_drive),
    .data_valid(data_valid),
    .wr_strobe (wr_strobe),
    .err_busy  (err_busy)
);

// File: tb/sdram_burst_timer_bench.sv
module sdram_burst_timer_bench;

    localparam int PAGE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [9:0] mode_word = '0;
    logic       bus_drive, data_valid, wr_strobe, busy, err_busy, err_reserved, err_speed;

    logic [1:0] cmd_f = 2'b00;
    logic [9:0] mode_f = '0;
    logic       f_drive, f_valid, f_wr, f_busy, f_ebusy, f_ersv, f_espd;

    int total = 0;
    int bad = 0;
    int m_cl = 3;
    int m_bl = 1;
    bit m_single = 1'b0;

    always #5 clk = ~clk;

    sdram_burst_timer #(.PAGE_LEN(PAGE)) u_sdram_burst_timer (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .mode_word(mode_word),
        .bus_drive(bus_drive), .data_valid(data_valid), .wr_strobe(wr_strobe),
        .busy(busy), .err_busy(err_busy), .err_reserved(err_reserved), .err_speed(err_speed)
    );

    sdram_burst_timer #(.PAGE_LEN(PAGE), .CLK_MHZ(110)) u_fast (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_f), .mode_word(mode_f),
        .bus_drive(f_drive), .data_valid(f_valid), .wr_strobe(f_wr),
        .busy(f_busy), .err_busy(f_ebusy), .err_reserved(f_ersv), .err_speed(f_espd)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bl_of(input logic [2:0] c);
        case (c)
            3'b000:  return 1;
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return PAGE;
        endcase
    endfunction

    function automatic bit rsv_of(input logic [9:0] w);
        bit bl_ok = (w[2:0] <= 3'b011) || (w[2:0] == 3'b111);
        bit cl_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
        return (w[8:7] != 2'b00) || !bl_ok || !cl_ok;
    endfunction

    function automatic bit spd_of(input logic [9:0] w, input int mhz);
        if (rsv_of(w)) return 1'b0;
        if (w[6:4] == 3'b010) return mhz > 100;
        return mhz > 125;
    endfunction

    function automatic logic [9:0] mk_word(input bit single, input logic [2:0] cl, input logic [2:0] bl);
        return {single, 2'b00, cl, 1'b0, bl};
    endfunction

    task automatic load_word(input logic [9:0] w);
        bit er = rsv_of(w);
        bit es = spd_of(w, 100);
        @(negedge clk);
        cmd = 2'b11;
        mode_word = w;
        @(negedge clk);
        cmd = 2'b00;
        chk("R3", int'(err_reserved), int'(er), "reserved flag after load");
        chk("R4", int'(err_speed), int'(es), "speed flag after load");
        if (!er && !es) begin
            m_cl = (w[6:4] == 3'b011) ? 3 : 2;
            m_bl = bl_of(w[2:0]);
            m_single = w[9];
        end
    endtask

    // READ with an optional command injected while busy (R10)
    task automatic do_read(input string tag, input logic [1:0] inj, input logic [9:0] inj_w);
        int first_drive = -1, last_drive = -1, first_dv = -1, dv_cnt = 0;
        int busy_end = -1;
        int span = m_cl + m_bl;
        @(negedge clk);
        cmd = 2'b01;
        for (int k = 0; k <= span; k++) begin
            @(negedge clk);
            if (k == 0) cmd = 2'b00;
            if (bus_drive && first_drive < 0) first_drive = k;
            if (bus_drive) last_drive = k;
            if (data_valid && first_dv < 0) first_dv = k;
            if (data_valid) dv_cnt++;
            if (!busy && busy_end < 0) busy_end = k;
            if (k == 2 && inj != 2'b00) begin
                cmd = 2'b00;
                chk("R10", int'(err_busy), 1, "busy error after injected command");
                chk("R10", int'(err_reserved) + int'(err_speed), 0, "no load flag while busy");
            end
            if (k == 1 && inj != 2'b00) begin
                cmd = inj;
                mode_word = inj_w;
            end
        end
        chk({"R5 ", tag}, first_drive, m_cl - 1, "first bus drive cycle");
        chk({"R6 ", tag}, first_dv, m_cl, "first valid cycle");
        chk({"R6 ", tag}, dv_cnt, m_bl, "valid beat count");
        chk({"R7 ", tag}, last_drive, m_cl + m_bl - 1, "last bus drive cycle");
        chk({"R10 ", tag}, busy_end, span, "busy release cycle");
    endtask

    task automatic do_write(input string tag);
        int n = m_single ? 1 : m_bl;
        int first_st = -1, st_cnt = 0, drv = 0, busy_end = -1;
        @(negedge clk);
        cmd = 2'b10;
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (k == 0) cmd = 2'b00;
            if (wr_strobe && first_st < 0) first_st = k;
            if (wr_strobe) st_cnt++;
            if (bus_drive) drv++;
            if (!busy && busy_end < 0) busy_end = k;
        end
        chk({m_single ? "R9 " : "R8 ", tag}, st_cnt, n, "write strobe count");
        chk({"R8 ", tag}, first_st, 0, "first write strobe cycle");
        chk({"R8 ", tag}, drv, 0, "bus drive during write");
        chk({"R10 ", tag}, busy_end, n, "busy release after write");
    endtask

    initial begin
        #(10 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int quiet;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R11 NOP holds everything quiet
        quiet = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            quiet += int'(busy) + int'(bus_drive) + int'(data_valid) + int'(wr_strobe)
                   + int'(err_busy) + int'(err_reserved) + int'(err_speed);
        end
        chk("R1 R11", quiet, 0, "outputs active after reset under NOP");
        do_read("R1 default", 2'b00, '0);
        do_write("R1 default");

        // R2 directed settings
        load_word(mk_word(1'b0, 3'b010, 3'b011));
        do_read("R2 cl2 bl8", 2'b00, '0);
        do_write("R2 bl8");
        load_word(mk_word(1'b0, 3'b011, 3'b111));
        do_read("R2 full page", 2'b00, '0);
        do_write("R2 full page");
        load_word(mk_word(1'b1, 3'b010, 3'b010));
        do_read("R9 read keeps bl4", 2'b00, '0);
        do_write("R9 single");

        // R3 rejected words keep the settings
        load_word({1'b0, 2'b01, 3'b011, 1'b0, 3'b000});
        load_word(mk_word(1'b0, 3'b011, 3'b100));
        load_word(mk_word(1'b0, 3'b001, 3'b000));
        do_read("R3 settings kept", 2'b00, '0);

        // R10 commands while busy
        load_word(mk_word(1'b0, 3'b011, 3'b010));
        do_read("R10 inj read", 2'b01, '0);
        do_read("R10 inj load", 2'b11, mk_word(1'b0, 3'b010, 3'b000));
        do_read("R10 after load", 2'b10, '0);

        // R4 faster clock refuses latency 2
        @(negedge clk);
        cmd_f = 2'b11;
        mode_f = mk_word(1'b0, 3'b010, 3'b000);
        @(negedge clk);
        cmd_f = 2'b00;
        chk("R4", int'(f_espd), 1, "latency 2 refused at 110 MHz");
        cmd_f = 2'b01;
        begin
            int fv = -1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (k == 0) cmd_f = 2'b00;
                if (f_valid && fv < 0) fv = k;
            end
            chk("R4", fv, 3, "fast instance kept latency 3");
        end
        @(negedge clk);
        cmd_f = 2'b11;
        mode_f = mk_word(1'b0, 3'b011, 3'b000);
        @(negedge clk);
        cmd_f = 2'b00;
        chk("R4", int'(f_espd), 0, "latency 3 accepted at 110 MHz");

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [9:0] w;
            int r = int'($urandom % 4);
            w[9]   = 1'($urandom);
            w[8:7] = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            w[6:4] = (r == 0) ? 3'b010 : (r == 3) ? 3'($urandom) : 3'b011;
            w[3]   = 1'($urandom);
            w[2:0] = 3'($urandom);
            load_word(w);
            for (int j = 0; j < 2; j++) begin
                if ($urandom % 2 == 0) begin
                    if (m_cl + m_bl >= 3 && $urandom % 3 == 0)
                        do_read("R10 random", 2'($urandom % 3 + 1), 10'($urandom));
                    else
                        do_read("R6 random", 2'b00, '0);
                end else begin
                    do_write("R8 random");
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule